// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The block manages sixteen general-purpose pins split into two banks of eight. A byte-wide register bus configures and observes them. The bus has an 8-bit address, a write strobe, a read strobe and a read-data return. Each pin has two control registers. The output-side register sets direction, push-pull or open-drain drive, the pull enable with its strength and polarity, and the driven level. The input-side register reads back the synchronized pin level and selects which edges raise an interrupt.

Detected edges set per-pin pending bits, which are grouped into one byte per bank. A matching mask byte per bank gates those pending bits onto a single active-high interrupt line. Software clears a pending bit by writing 1 to it. Two further mask bytes and a panel-control byte are plain storage, and the panel byte is also brought out on a port. The pad side is modelled as output value, output enable and pull-control signals.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `pad_oe`, `pad_out` and the pull outputs are 0, and `irq` is low.
- R2: Pin k of bank 0 has its output register at 0x2B+k and pin k of bank 1 at 0x3B+k. Bits 5:0 are stored and bits 7:6 read as 0. `bus_rdata` presents the addressed byte one clock after a cycle with `bus_re` high, and is 0x00 in every other cycle.
- R3: Output-register bit 5 is the direction (1 = output) and bit 0 is the level. In push-pull mode (bit 4 = 0) `pad_oe` equals bit 5 and `pad_out` equals bit 0. With bit 5 at 0, `pad_oe` is always 0.
- R4: With bit 4 at 1 (open-drain), `pad_out` is 0. `pad_oe` is asserted only when bit 5 is 1 and bit 0 is 0.
- R5: Output-register bit 3 drives `pull_en`. Bits 2:1 select the pull: bit 1 drives `pull_up` (1 = up) and bit 2 drives `pull_weak` (1 = 50k, 0 = 2k).
- R6: Pin k has its input register at 0x33+k in bank 0 and 0x43+k in bank 1. Bit 0 returns the pin level after a two-flop synchronizer. Bits 2:1 hold the edge select and all other bits read as 0.
- R7: The edge select codes are 00 = none, 01 = falling, 10 = rising and 11 = both. A selected edge on the synchronized level sets bit k of the pending byte, at 0x0B for bank 0 and 0x0C for bank 1.
- R8: Writing a pending byte clears the bits written as 1 and leaves the bits written as 0. An edge in the same cycle as its clear leaves the bit set.
- R9: The mask bytes are at 0x19 for bank 0 and 0x1A for bank 1, and a 1 masks the pin. `irq` is the OR over all pins of pending AND NOT mask. Pending bits still latch while masked.
- R10: The bytes at 0x1B, 0x1C and 0x52 are full 8-bit read/write storage. The 0x52 byte also drives `panel_ctl`.
- R11: Reads from any address not named above return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_re` |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pull_en | output | 16 | Pull resistor enable |
| pull_up | output | 16 | Pull direction, 1 = up |
| pull_weak | output | 16 | Pull strength, 1 = 50k, 0 = 2k |
| panel_ctl | output | 8 | Panel-control byte |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A pending bit that is wrongly held, dropped or set shows on `irq` in the same cycle it changes, provided the pin is unmasked. It also shows on the next read of its bank's pending byte. A wrong edge-select or synchronizer state moves the moment a pending bit appears, so edges are timed to hit a clear write in the exact cycle the bit latches. A corrupted output register appears on the pad and pull pins combinationally, with no extra delay beyond the write edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int BYTE_W = 8;
   localparam logic [7:0] A_PEND0   = 8'h0B;
   localparam logic [7:0] A_MASK0   = 8'h19;
   localparam logic [7:0] A_AUX0    = 8'h1B;
   localparam logic [7:0] A_OCTL0   = 8'h2B;
   localparam logic [7:0] A_ICTL0   = 8'h33;
   localparam logic [7:0] A_PANEL   = 8'h52;
   localparam int         BANK_STEP = 16;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   // output-side control byte, bits 5:0 (bits 7:6 unused)
   typedef struct packed {
      logic       dir;
      logic       odrain;
      logic       pull_on;
      logic [1:0] pull_sel;
      logic       level;
   } octl_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpx_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d_async;
         else             chain[s] <= chain[(s > 0) ? s-1 : 0];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpx_pin.sv
module gpx_pin
   import gpx_pkg::*;
#(
   parameter logic [7:0] A_OUT = 8'h2B,
   parameter logic [7:0] A_IN  = 8'h33
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   input  logic        bus_we,
   input  logic        lvl_sync,
   output logic        edge_ev,
   output logic [7:0]  rd_val,
   output logic        pad_out,
   output logic        pad_oe,
   output logic        pull_en,
   output logic        pull_up,
   output logic        pull_weak
);
   octl_t     oc;
   edge_sel_e esel;
   logic      lvl_prev;
   logic      rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc       <= '0;
         esel     <= EDGE_OFF;
         lvl_prev <= 1'b0;
      end else begin
         lvl_prev <= lvl_sync;
         if (bus_we && bus_addr == A_OUT) oc   <= octl_t'(bus_wdata[5:0]);
         if (bus_we && bus_addr == A_IN)  esel <= edge_sel_e'(bus_wdata[2:1]);
      end
   end

   assign rise = lvl_sync & ~lvl_prev;
   assign fall = ~lvl_sync & lvl_prev;

   always_comb begin
      unique case (esel)
         EDGE_FALL: edge_ev = fall;
         EDGE_RISE: edge_ev = rise;
         EDGE_ANY:  edge_ev = rise | fall;
         default:   edge_ev = 1'b0;
      endcase
   end

   always_comb begin
      if (bus_addr == A_OUT)     rd_val = {2'b00, oc};
      else if (bus_addr == A_IN) rd_val = {5'b00000, esel, lvl_sync};
      else                       rd_val = 8'h00;
   end

   always_comb begin
      if (oc.odrain) begin
         pad_out = 1'b0;
         pad_oe  = oc.dir & ~oc.level;
      end else begin
         pad_out = oc.level;
         pad_oe  = oc.dir;
      end
   end

   assign pull_en   = oc.pull_on;
   assign pull_up   = oc.pull_sel[0];
   assign pull_weak = oc.pull_sel[1];

   p_pad_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_OUT && !bus_wdata[5]) |=> !pad_oe);
   p_od_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_OUT && bus_wdata[4]) |=> !pad_out);
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
   parameter int         W      = 8,
   parameter logic [7:0] A_PEND = 8'h0B,
   parameter logic [7:0] A_MASK = 8'h19,
   parameter logic [7:0] A_AUX  = 8'h1B
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [7:0]   bus_addr,
   input  logic [7:0]   bus_wdata,
   input  logic         bus_we,
   input  logic [W-1:0] edge_ev,
   output logic [7:0]   rd_val,
   output logic         irq
);
   if (W != 8) begin : g_bad_width
      $error("gpx_bank: bank width must match the byte bus");
   end

   logic [W-1:0] pend, mask, aux;
   logic         pend_wr;
   logic [W-1:0] clr;

   assign pend_wr = bus_we && bus_addr == A_PEND;
   assign clr     = pend_wr ? bus_wdata[W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         mask <= '0;
         aux  <= '0;
      end else begin
         pend <= (pend & ~clr) | edge_ev;
         if (bus_we && bus_addr == A_MASK) mask <= bus_wdata[W-1:0];
         if (bus_we && bus_addr == A_AUX)  aux  <= bus_wdata[W-1:0];
      end
   end

   always_comb begin
      if (bus_addr == A_PEND)      rd_val = pend;
      else if (bus_addr == A_MASK) rd_val = mask;
      else if (bus_addr == A_AUX)  rd_val = aux;
      else                         rd_val = 8'h00;
   end

   assign irq = |(pend & ~mask);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_wr |=> (pend & $past(bus_wdata[W-1:0] & ~edge_ev)) == '0);
   p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_ev) |=> (pend & $past(edge_ev)) == $past(edge_ev));
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_wr |=> (pend & $past(pend)) == $past(pend));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpx_pkg::*;
#(
   parameter int N_BANK      = 2,
   parameter int BANK_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   input  logic        bus_we,
   input  logic        bus_re,
   output logic [7:0]  bus_rdata,
   input  logic [15:0] pin_in,
   output logic [15:0] pad_out,
   output logic [15:0] pad_oe,
   output logic [15:0] pull_en,
   output logic [15:0] pull_up,
   output logic [15:0] pull_weak,
   output logic [7:0]  panel_ctl,
   output logic        irq
);
   localparam int NPIN = N_BANK * BANK_W;

   if (N_BANK < 1 || N_BANK > 2) begin : g_bad_banks
      $error("gpio_edge_ctrl: status bytes allow one or two banks");
   end
   if (NPIN != 16) begin : g_bad_pins
      $error("gpio_edge_ctrl: pin ports are sixteen wide");
   end

   logic [NPIN-1:0] lvl_sync, edge_ev;
   logic [7:0]      rd_pin  [NPIN];
   logic [7:0]      rd_bank [N_BANK];
   logic [N_BANK-1:0] irq_bank;
   logic [7:0]      panel_q;
   logic [7:0]      rd_mux;

   gpx_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(lvl_sync));

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      for (genvar k = 0; k < BANK_W; k++) begin : g_pin
         localparam int P = b*BANK_W + k;
         localparam logic [7:0] AO = 8'(int'(A_OCTL0) + b*BANK_STEP + k);
         localparam logic [7:0] AI = 8'(int'(A_ICTL0) + b*BANK_STEP + k);
         gpx_pin #(.A_OUT(AO), .A_IN(AI)) i_pin (
            .clk(clk), .rst_n(rst_n),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
            .lvl_sync(lvl_sync[P]), .edge_ev(edge_ev[P]), .rd_val(rd_pin[P]),
            .pad_out(pad_out[P]), .pad_oe(pad_oe[P]),
            .pull_en(pull_en[P]), .pull_up(pull_up[P]), .pull_weak(pull_weak[P]));
      end
      gpx_bank #(
         .W(BANK_W),
         .A_PEND(8'(int'(A_PEND0) + b)),
         .A_MASK(8'(int'(A_MASK0) + b)),
         .A_AUX (8'(int'(A_AUX0)  + b))
      ) i_bank (
         .clk(clk), .rst_n(rst_n),
         .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
         .edge_ev(edge_ev[b*BANK_W +: BANK_W]),
         .rd_val(rd_bank[b]), .irq(irq_bank[b]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) panel_q <= '0;
      else if (bus_we && bus_addr == A_PANEL) panel_q <= bus_wdata;
   end

   always_comb begin
      rd_mux = (bus_addr == A_PANEL) ? panel_q : 8'h00;
      for (int p = 0; p < NPIN; p++)   rd_mux |= rd_pin[p];
      for (int b = 0; b < N_BANK; b++) rd_mux |= rd_bank[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= 8'h00;
      else if (bus_re) bus_rdata <= rd_mux;
      else             bus_rdata <= 8'h00;
   end

   assign panel_ctl = panel_q;
   assign irq       = |irq_bank;

   p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> bus_rdata == 8'h00);
   p_panel_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_PANEL) |=> panel_ctl == $past(bus_wdata));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0, bus_wdata = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pad_out, pad_oe, pull_en, pull_up, pull_weak;
   logic [7:0]  panel_ctl;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct { logic [7:0] exp; string tag; logic [7:0] addr; } item_t;
   item_t sb_q[$];
   logic  rd_fire = 1'b0;

   always #5 clk = ~clk;

   gpio_edge_ctrl i_gpio_edge_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en), .pull_up(pull_up),
      .pull_weak(pull_weak), .panel_ctl(panel_ctl), .irq(irq));

   // monitor: a read strobe sampled at a rising edge yields data at the next falling edge
   always @(posedge clk) rd_fire <= bus_re;
   always @(negedge clk) begin
      if (rd_fire) begin
         item_t it;
         n_chk++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: unexpected read data got %02h expected none", bus_rdata);
         end else begin
            it = sb_q.pop_front();
            if (bus_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: read %02h got %02h expected %02h",
                        it.tag, it.addr, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk);
      it.exp = e; it.tag = tag; it.addr = a;
      sb_q.push_back(it);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk(input logic [15:0] act, input logic [15:0] e, input string tag);
      n_chk++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s: got %04h expected %04h", tag, act, e);
      end
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pad_oe, 16'h0000, "R1 pad_oe");
      chk(pull_en, 16'h0000, "R1 pull_en");
      chk({15'b0, irq}, 16'h0000, "R1 irq");
      rd(8'h2B, 8'h00, "R1 octl");
      rd(8'h43, 8'h00, "R1 ictl");
      rd(8'h0B, 8'h00, "R1 pend");
      rd(8'h52, 8'h00, "R1 panel");

      // R2 output register storage and map
      wr(8'h2B, 8'hFF);
      rd(8'h2B, 8'h3F, "R2 bank0 octl");
      wr(8'h42, 8'h21);
      rd(8'h42, 8'h21, "R2 bank1 octl pin15");
      chk(pad_oe & 16'h8000, 16'h8000, "R2 pin15 oe");

      // R3 push-pull
      wr(8'h2B, 8'h21);
      chk({pad_oe[0], pad_out[0]}, 16'h0003, "R3 pp high");
      wr(8'h2B, 8'h20);
      chk({pad_oe[0], pad_out[0]}, 16'h0002, "R3 pp low");
      wr(8'h2B, 8'h01);
      chk({pad_oe[0], pad_out[0]}, 16'h0001, "R3 input dir");

      // R4 open drain
      wr(8'h2B, 8'h31);
      chk({pad_oe[0], pad_out[0]}, 16'h0000, "R4 od release");
      wr(8'h2B, 8'h30);
      chk({pad_oe[0], pad_out[0]}, 16'h0002, "R4 od drive low");

      // R5 pull controls
      wr(8'h2C, 8'h0E);
      chk({pull_en[1], pull_up[1], pull_weak[1]}, 16'h0007, "R5 50k up");
      wr(8'h2C, 8'h04);
      chk({pull_en[1], pull_up[1], pull_weak[1]}, 16'h0001, "R5 off 50k down");

      // R6 input readback and edge field
      pin_in[9] = 1'b1;
      settle();
      rd(8'h44, 8'h01, "R6 level");
      wr(8'h44, 8'hFF);
      rd(8'h44, 8'h07, "R6 field");
      wr(8'h44, 8'h00);

      // R7 rising on pin3
      wr(8'h36, 8'h04);
      pin_in[3] = 1'b1; settle();
      rd(8'h0B, 8'h08, "R7 rise");
      chk({15'b0, irq}, 16'h0001, "R9 irq on");
      wr(8'h0B, 8'h08);
      rd(8'h0B, 8'h00, "R8 clear");
      chk({15'b0, irq}, 16'h0000, "R9 irq off");
      pin_in[3] = 1'b0; settle();
      rd(8'h0B, 8'h00, "R7 rise ignores fall");
      // falling on pin4
      wr(8'h37, 8'h02);
      pin_in[4] = 1'b1; settle();
      rd(8'h0B, 8'h00, "R7 fall ignores rise");
      pin_in[4] = 1'b0; settle();
      rd(8'h0B, 8'h10, "R7 fall");
      // R8 write of zeros leaves bit
      wr(8'h0B, 8'hEF);
      rd(8'h0B, 8'h10, "R8 zero keeps");
      wr(8'h0B, 8'h10);
      rd(8'h0B, 8'h00, "R8 one clears");
      // both edges on pin12
      wr(8'h47, 8'h06);
      pin_in[12] = 1'b1; settle();
      rd(8'h0C, 8'h10, "R7 both up");
      wr(8'h0C, 8'h10);
      pin_in[12] = 1'b0; settle();
      rd(8'h0C, 8'h10, "R7 both down");
      // R8 edge and clear in the same cycle
      wr(8'h0C, 8'h10);
      rd(8'h0C, 8'h00, "R8 cleared");
      pin_in[12] = 1'b1; settle();
      @(negedge clk);
      pin_in[12] = 1'b0;
      @(negedge clk);
      wr(8'h0C, 8'h10);
      rd(8'h0C, 8'h10, "R8 edge wins");
      wr(8'h0C, 8'h10);

      // R9 mask
      wr(8'h19, 8'h08);
      rd(8'h19, 8'h08, "R9 mask store");
      pin_in[3] = 1'b1; settle();
      rd(8'h0B, 8'h08, "R9 latch while masked");
      chk({15'b0, irq}, 16'h0000, "R9 masked irq");
      wr(8'h19, 8'h00);
      chk({15'b0, irq}, 16'h0001, "R9 unmask irq");
      wr(8'h0B, 8'hFF);
      chk({15'b0, irq}, 16'h0000, "R9 cleared irq");

      // R10 storage bytes
      wr(8'h1B, 8'hA5);
      wr(8'h1C, 8'h5A);
      wr(8'h52, 8'h3C);
      rd(8'h1B, 8'hA5, "R10 aux0");
      rd(8'h1C, 8'h5A, "R10 aux1");
      rd(8'h52, 8'h3C, "R10 panel");
      chk({8'h00, panel_ctl}, 16'h003C, "R10 panel port");

      // R11 unmapped
      rd(8'h00, 8'h00, "R11 0x00");
      rd(8'h4B, 8'h00, "R11 0x4B");
      rd(8'h53, 8'h00, "R11 0x53");
      rd(8'h1D, 8'h00, "R11 0x1D");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: %0d reads unanswered expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(negedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule